// File: doc/BRIEF.md
# Flash Read-Retry Mode Sequencer

This block moves a raw NAND flash device into one of several read-retry modes. A controller gives it a mode index and a one-cycle start pulse. The block then plays a fixed sequence of beats on a byte-wide flash bus. Each beat is one of three kinds: a command beat, an address beat or a data-out beat, and each kind has its own strobe.

The sequence has three parts. First comes a command beat that puts the device into parameter-set mode. Next, for each tuning register in turn, the block sends the register's address and then the byte chosen for the requested mode. Last comes a command beat that makes the new settings take effect.

The tuning bytes come from an internal table. The table holds one byte per register per mode and is filled through a simple write port. The register addresses come from a fixed list. Before each beat the block waits for the bus to signal that it is ready. The block pulses `done` when the sequence ends. It pulses `err` when the start request names a mode that does not exist.

Top module: `flash_retry_seq`

## Requirements
- R1: The first beat after an accepted start is a command beat with byte 0x36.
- R2: For each register index i, counting up from 0 to NREGS-1, an address beat is followed by a data beat, and no command beat falls between them.
- R3: The data beat for register i in mode m carries the table entry at index m*NREGS+i, which was written through tbl_waddr.
- R4: The last beat of a sequence is a command beat with byte 0x16.
- R5: Address beats carry the register addresses in this order: 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF.
- R6: A start with mode >= NMODES raises err for exactly one cycle, in the cycle after the start. No strobe is raised and no sequence begins.
- R7: A beat appears only in the cycle after a clock edge at which bus_ready was high. Each strobe lasts one cycle, at most one strobe is high at a time, and bus_byte is 0 whenever no strobe is high.
- R8: done is high for exactly one cycle, in the cycle after the apply beat.
- R9: A start that arrives while a sequence is running is ignored.
- R10: After reset, all strobes, bus_byte, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to switch mode |
| mode | input | MODE_W (4) | Requested read-retry mode |
| tbl_we | input | 1 | Write enable for the value table |
| tbl_waddr | input | clog2(NMODES*NREGS) (6) | Table write index |
| tbl_wdata | input | DW (8) | Table write byte |
| bus_ready | input | 1 | Bus can take a beat |
| bus_cmd_vld | output | 1 | Command beat strobe |
| bus_addr_vld | output | 1 | Address beat strobe |
| bus_data_vld | output | 1 | Data-out beat strobe |
| bus_byte | output | DW (8) | Byte carried by the current beat |
| done | output | 1 | Sequence finished pulse |
| err | output | 1 | Rejected-mode pulse |

## Verification
A wrong internal state shows at the ports within one cycle of the next ready edge. A wrong register index appears as an address byte out of order or a data byte taken from the wrong table entry. A latched mode that is off by one shifts every data byte by one table row. A wrong phase appears as a strobe of the wrong kind, or as a beat that is missing or extra. The bench models the expected beat stream as a queue and compares every output on every cycle, so each of these faults is caught on the first beat it affects.

// File: rtl/flash_rr_pkg.sv
package flash_rr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_ADDR,
        ST_DATA,
        ST_APPLY,
        ST_DONE
    } rr_state_e;
endpackage

// File: rtl/rr_value_table.sv
module rr_value_table #(
    parameter int NMODES = 8,
    parameter int NREGS  = 8,
    parameter int DW     = 8,
    localparam int DEPTH = NMODES * NREGS,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rr_addr_list.sv
module rr_addr_list #(
    parameter int NREGS = 8,
    localparam int RW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic [RW-1:0] idx,
    output logic [7:0]    reg_addr
);
    function automatic logic [7:0] addr_of(input int k);
        case (k % 8)
            0: addr_of = 8'hCC;
            1: addr_of = 8'hBF;
            2: addr_of = 8'hAA;
            3: addr_of = 8'hAB;
            4: addr_of = 8'hCD;
            5: addr_of = 8'hAD;
            6: addr_of = 8'hAE;
            default: addr_of = 8'hAF;
        endcase
    endfunction

    logic [7:0] list_w [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_list
        assign list_w[g] = addr_of(g);
    end

    assign reg_addr = list_w[idx];
endmodule

// File: rtl/rr_seq_fsm.sv
module rr_seq_fsm
    import flash_rr_pkg::*;
#(
    parameter int NMODES = 8,
    parameter int NREGS  = 8,
    parameter int DW     = 8,
    parameter int MODE_W = 4,
    parameter logic [DW-1:0] ENTER_OP = 8'h36,
    parameter logic [DW-1:0] APPLY_OP = 8'h16,
    localparam int IW = $clog2(NMODES * NREGS),
    localparam int RW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic              bus_ready,
    input  logic [DW-1:0]     tbl_rdata,
    input  logic [7:0]        reg_addr,
    output logic [IW-1:0]     tbl_raddr,
    output logic [RW-1:0]     reg_idx,
    output logic              bus_cmd_vld,
    output logic              bus_addr_vld,
    output logic              bus_data_vld,
    output logic [DW-1:0]     bus_byte,
    output logic              done,
    output logic              err
);
    localparam logic [RW-1:0] LAST_IDX = RW'(NREGS - 1);
    localparam logic [IW-1:0] NREGS_W  = IW'(NREGS);

    typedef struct packed {
        rr_state_e         state;
        logic [MODE_W-1:0] mode;
        logic [RW-1:0]     idx;
        logic              cmd;
        logic              addr;
        logic              data;
        logic [DW-1:0]     byte_o;
        logic              done;
        logic              err;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        r_d.cmd    = 1'b0;
        r_d.addr   = 1'b0;
        r_d.data   = 1'b0;
        r_d.byte_o = '0;
        r_d.done   = 1'b0;
        r_d.err    = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (32'(mode) >= NMODES) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.mode  = mode;
                        r_d.idx   = '0;
                        r_d.state = ST_ENTER;
                    end
                end
            end
            ST_ENTER: begin
                if (bus_ready) begin
                    r_d.cmd    = 1'b1;
                    r_d.byte_o = ENTER_OP;
                    r_d.idx    = '0;
                    r_d.state  = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (bus_ready) begin
                    r_d.addr   = 1'b1;
                    r_d.byte_o = DW'(reg_addr);
                    r_d.state  = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bus_ready) begin
                    r_d.data   = 1'b1;
                    r_d.byte_o = tbl_rdata;
                    if (r_q.idx == LAST_IDX) begin
                        r_d.state = ST_APPLY;
                    end else begin
                        r_d.idx   = r_q.idx + 1'b1;
                        r_d.state = ST_ADDR;
                    end
                end
            end
            ST_APPLY: begin
                if (bus_ready) begin
                    r_d.cmd    = 1'b1;
                    r_d.byte_o = APPLY_OP;
                    r_d.state  = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tbl_raddr    = IW'(r_q.mode) * NREGS_W + IW'(r_q.idx);
    assign reg_idx      = r_q.idx;
    assign bus_cmd_vld  = r_q.cmd;
    assign bus_addr_vld = r_q.addr;
    assign bus_data_vld = r_q.data;
    assign bus_byte     = r_q.byte_o;
    assign done         = r_q.done;
    assign err          = r_q.err;

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_cmd_vld, bus_addr_vld, bus_data_vld}));
    assert_beat_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_vld || bus_addr_vld || bus_data_vld) |-> $past(bus_ready));
    assert_no_cmd_after_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_vld |=> !bus_cmd_vld);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_cmd_vld));
    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !(bus_cmd_vld || bus_addr_vld || bus_data_vld));
endmodule

// File: rtl/flash_retry_seq.sv
module flash_retry_seq #(
    parameter int NMODES = 8,
    parameter int NREGS  = 8,
    parameter int DW     = 8,
    parameter int MODE_W = 4,
    localparam int IW    = $clog2(NMODES * NREGS),
    localparam int RW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic              tbl_we,
    input  logic [IW-1:0]     tbl_waddr,
    input  logic [DW-1:0]     tbl_wdata,
    input  logic              bus_ready,
    output logic              bus_cmd_vld,
    output logic              bus_addr_vld,
    output logic              bus_data_vld,
    output logic [DW-1:0]     bus_byte,
    output logic              done,
    output logic              err
);
    logic [IW-1:0] raddr_w;
    logic [DW-1:0] rdata_w;
    logic [RW-1:0] idx_w;
    logic [7:0]    reg_addr_w;

    rr_value_table #(.NMODES(NMODES), .NREGS(NREGS), .DW(DW)) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (raddr_w),
        .rdata (rdata_w)
    );

    rr_addr_list #(.NREGS(NREGS)) u_addr (
        .idx      (idx_w),
        .reg_addr (reg_addr_w)
    );

    rr_seq_fsm #(.NMODES(NMODES), .NREGS(NREGS), .DW(DW), .MODE_W(MODE_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .mode         (mode),
        .bus_ready    (bus_ready),
        .tbl_rdata    (rdata_w),
        .reg_addr     (reg_addr_w),
        .tbl_raddr    (raddr_w),
        .reg_idx      (idx_w),
        .bus_cmd_vld  (bus_cmd_vld),
        .bus_addr_vld (bus_addr_vld),
        .bus_data_vld (bus_data_vld),
        .bus_byte     (bus_byte),
        .done         (done),
        .err          (err)
    );
endmodule

// File: tb/tb_flash_retry_seq.sv
module tb_flash_retry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 8;
    localparam int NR = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] mode = '0;
    logic       tbl_we = 1'b0;
    logic [5:0] tbl_waddr = '0;
    logic [7:0] tbl_wdata = '0;
    logic       bus_ready = 1'b0;
    logic       bus_cmd_vld, bus_addr_vld, bus_data_vld, done, err;
    logic [7:0] bus_byte;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_retry_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .bus_ready(bus_ready), .bus_cmd_vld(bus_cmd_vld), .bus_addr_vld(bus_addr_vld),
        .bus_data_vld(bus_data_vld), .bus_byte(bus_byte), .done(done), .err(err)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit ended = 0;

    // behavioural reference: queue of expected beats
    // kinds: 1 command, 2 address, 3 data (value holds table index), 4 done
    int  q_kind[$];
    int  q_val[$];
    logic [7:0] model_tbl [NM*NR];
    logic e_cmd = 0, e_addr = 0, e_data = 0, e_done = 0, e_err = 0;
    logic [7:0] e_byte = 0;

    function automatic logic [7:0] reg_list(input int k);
        logic [7:0] l [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
        return l[k];
    endfunction

    always @(posedge clk) begin
        e_cmd <= 0; e_addr <= 0; e_data <= 0; e_done <= 0; e_err <= 0; e_byte <= 0;
        if (!rst_n) begin
            q_kind.delete(); q_val.delete();
        end else if (q_kind.size() == 0) begin
            // R9: starts only honoured when the queue is empty
            if (start) begin
                if (int'(mode) >= NM) e_err <= 1;
                else begin
                    q_kind.push_back(1); q_val.push_back(8'h36);
                    for (int i = 0; i < NR; i++) begin
                        q_kind.push_back(2); q_val.push_back(reg_list(i));
                        q_kind.push_back(3); q_val.push_back(int'(mode) * NR + i);
                    end
                    q_kind.push_back(1); q_val.push_back(8'h16);
                    q_kind.push_back(4); q_val.push_back(0);
                end
            end
        end else if (q_kind[0] == 4) begin
            void'(q_kind.pop_front()); void'(q_val.pop_front());
            e_done <= 1;
        end else if (bus_ready) begin
            int k, v;
            k = q_kind.pop_front(); v = q_val.pop_front();
            case (k)
                1: begin e_cmd <= 1; e_byte <= 8'(v); end
                2: begin e_addr <= 1; e_byte <= 8'(v); end
                default: begin e_data <= 1; e_byte <= model_tbl[v]; end
            endcase
        end
        if (tbl_we) model_tbl[tbl_waddr] = tbl_wdata;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
        end
    endtask

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R1_R4 cmd strobe", {7'd0, bus_cmd_vld}, {7'd0, e_cmd});
            chk("R2_R5 addr strobe", {7'd0, bus_addr_vld}, {7'd0, e_addr});
            chk("R2_R3 data strobe", {7'd0, bus_data_vld}, {7'd0, e_data});
            chk("R7 bus byte", bus_byte, e_byte);
            chk("R8 done", {7'd0, done}, {7'd0, e_done});
            chk("R6 err", {7'd0, err}, {7'd0, e_err});
        end
    end

    bit rnd_ready = 0;
    always @(negedge clk) bus_ready <= rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;

    task automatic go(input int m);
        @(negedge clk); start = 1; mode = 4'(m);
        @(negedge clk); start = 0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset
        chk("R10 reset strobes", {5'd0, bus_cmd_vld, bus_addr_vld, bus_data_vld}, 8'd0);
        chk("R10 reset byte", bus_byte, 8'd0);
        chk("R10 reset flags", {6'd0, done, err}, 8'd0);
        for (int a = 0; a < NM * NR; a++) begin
            @(negedge clk); tbl_we = 1; tbl_waddr = 6'(a); tbl_wdata = 8'((a * 37) ^ 8'h5A);
        end
        @(negedge clk); tbl_we = 0;
        rst_n = 1;
        @(negedge clk);
        go(0); repeat (30) @(negedge clk);          // R1 R2 R3 R4 R5 R8
        go(8); repeat (4) @(negedge clk);           // R6 boundary
        go(15); repeat (4) @(negedge clk);          // R6
        go(7); repeat (30) @(negedge clk);          // last mode
        rnd_ready = 1;                              // R7 stalls
        go(3); repeat (5) @(negedge clk);
        go(5);                                      // R9 ignored while busy
        repeat (80) @(negedge clk);
        @(negedge clk); tbl_we = 1; tbl_waddr = 6'(2 * NR + 4); tbl_wdata = 8'hE1;
        @(negedge clk); tbl_we = 0;
        go(2); repeat (80) @(negedge clk);          // R3 rewritten entry
        go(9); repeat (4) @(negedge clk);
        rnd_ready = 0;
        go(6); repeat (30) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end
endmodule